// File: doc/BRIEF.md
# Phase-Aligned Input Capture Channel

This block is one input-capture channel that shares a free-running timebase with its own capture logic. The system clock is divided into a four-phase instruction cycle by a small phase counter. The pin is sampled once per instruction cycle, and a qualified edge acts once per instruction cycle, so the results line up with a slower instruction-cycle core. A qualified edge copies the running timer into a capture buffer and raises a sticky interrupt flag. Depending on the mode and on a reset-enable control, the edge can also clear the timer.

A 4-bit mode field selects the kind of measurement. The edge-capture group covers rising edges, falling edges, every Nth rising edge and every Mth rising edge. The other modes are period measurement, high-time or low-time pulse-width measurement, and any-edge state-change capture. A special trigger mode emits a one-cycle trigger pulse, clears the timer at the start of the next instruction cycle, and never raises the interrupt flag. An optional synchronizer of configurable depth sits in front of the sampler.

Top module: `ic_capture_chan`

## Requirements
- R1: While reset is held and just after it is released, phase_o is 0, tmr_o is 0, cap_buf_o is 0, cap_flag_o is 0 and trig_o is 0.
- R2: phase_o steps 0,1,2,3 and repeats, one step per clock. With IN_SYNC = 0, cap_i is sampled at the clock edge that moves phase_o from 0 to 1. A recognised edge updates cap_buf_o and cap_flag_o at the clock edge that moves phase_o from 2 to 3. A pin change made after the sample edge is recognised one instruction cycle later.
- R3: In mode 0001 each rising edge, and in mode 0010 each falling edge, loads tmr_o into cap_buf_o and sets cap_flag_o.
- R4: Mode 0011 captures on every EVERY_A-th rising edge and mode 0100 on every EVERY_B-th rising edge. Only the capturing edge sets the flag. The edge count restarts whenever mode_i changes.
- R5: Mode 0101 captures on every rising edge. With ren_i = 1 and tmr_en_i = 1, edges N instruction cycles apart capture the value 4N-1.
- R6: Mode 0110 clears the timer on a rising edge and captures on the next falling edge, giving 4H-1 for a high time of H instruction cycles. Mode 0111 does the same with the polarities swapped. ren_i has no effect in either mode.
- R7: Mode 1000 captures and sets the flag on every edge of either polarity.
- R8: In modes 0001 to 0101 and 1000, a capture with ren_i = 1 leaves tmr_o at 0. With ren_i = 0 the timer keeps counting through the capture.
- R9: Mode 1110 acts on rising edges and mode 1111 on falling edges. Each edge loads cap_buf_o and drives trig_o high for the one clock in which phase_o is 3. It never sets cap_flag_o. The timer is cleared at the next clock edge, where phase_o returns to 0.
- R10: Modes 0000 and 1001 to 1101 capture nothing, set no flag, pulse no trigger and clear no timer.
- R11: cap_flag_o stays set until a flag_clr_i strobe clears it. A set in the same clock as a clear wins.
- R12: tmr_o rises by one each clock while tmr_en_i is 1 and holds while it is 0, apart from clears. Changing mode_i never alters it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Measurement mode select |
| ren_i | input | 1 | Clear the timer on capture when set |
| tmr_en_i | input | 1 | Timebase count enable |
| cap_i | input | 1 | Capture pin |
| flag_clr_i | input | 1 | One-cycle clear strobe for the interrupt flag |
| tmr_o | output | TMR_W | Running timebase value |
| cap_buf_o | output | TMR_W | Capture buffer |
| cap_flag_o | output | 1 | Sticky interrupt flag |
| trig_o | output | 1 | Special trigger pulse |
| phase_o | output | 2 | Current phase, 0 to 3 |

## Verification
The bench builds the channel with IN_SYNC = 0. This removes the synchronizer latency, so the sample point of R2 sits exactly on the phase 0 to 1 clock edge, and both an early pin change and a late one can be placed on either side of it. TMR_W = 16, EVERY_A = 4 and EVERY_B = 16 keep their defaults. At these values the 16-edge prescaler runs to completion in a short run, and the measured intervals stay far below the timer's wrap point, so every expected capture follows directly from the 4N-1 and 4N-2 relations.

// File: rtl/ic_pkg.sv
package ic_pkg;

   typedef enum logic [2:0] {
      GRP_OFF,
      GRP_EDGE,
      GRP_PERIOD,
      GRP_PULSE,
      GRP_STATE,
      GRP_SPECIAL
   } grp_e;

   typedef enum logic [1:0] {
      PRE_NONE,
      PRE_A,
      PRE_B
   } presc_e;

   typedef struct packed {
      grp_e   grp;
      logic   use_fall;   // acting edge is falling (or start edge for pulse width)
      presc_e presc;
   } mode_dec_t;

   function automatic mode_dec_t decode_mode(input logic [3:0] m);
      mode_dec_t d;
      d = '{grp: GRP_OFF, use_fall: 1'b0, presc: PRE_NONE};
      unique case (m)
         4'b0001: d.grp = GRP_EDGE;
         4'b0010: begin d.grp = GRP_EDGE; d.use_fall = 1'b1; end
         4'b0011: begin d.grp = GRP_EDGE; d.presc = PRE_A; end
         4'b0100: begin d.grp = GRP_EDGE; d.presc = PRE_B; end
         4'b0101: d.grp = GRP_PERIOD;
         4'b0110: d.grp = GRP_PULSE;
         4'b0111: begin d.grp = GRP_PULSE; d.use_fall = 1'b1; end
         4'b1000: d.grp = GRP_STATE;
         4'b1110: d.grp = GRP_SPECIAL;
         4'b1111: begin d.grp = GRP_SPECIAL; d.use_fall = 1'b1; end
         default: d.grp = GRP_OFF;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/ic_phase_gen.sv
module ic_phase_gen (
   input  logic       clk,
   input  logic       rst_n,
   output logic [1:0] phase_o,
   output logic       st_sample_o,  // edge entering phase 2
   output logic       st_act_o,     // edge entering phase 4
   output logic       st_wrap_o     // edge entering phase 1
);

   logic [1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 2'd0;
      else        ph_q <= ph_q + 2'd1;
   end

   assign phase_o     = ph_q;
   assign st_sample_o = (ph_q == 2'd0);
   assign st_act_o    = (ph_q == 2'd2);
   assign st_wrap_o   = (ph_q == 2'd3);

endmodule

// File: rtl/ic_in_sync.sv
module ic_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_i} & {STAGES{1'b1}};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ic_edge_sampler.sv
module ic_edge_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_i,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   logic smp_q;
   logic vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q  <= 1'b0;
         vld_q  <= 1'b0;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end else if (sample_i) begin
         smp_q  <= pin_i;
         vld_q  <= 1'b1;
         rise_o <= vld_q &  pin_i & ~smp_q;
         fall_o <= vld_q & ~pin_i &  smp_q;
      end
   end

endmodule

// File: rtl/ic_event_ctrl.sv
module ic_event_ctrl #(
   parameter int EVERY_A = 4,
   parameter int EVERY_B = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] mode_i,
   input  logic       ren_i,
   input  logic       act_i,
   input  logic       rise_i,
   input  logic       fall_i,
   output logic       do_cap_o,
   output logic       do_clr_o,
   output logic       do_flag_o,
   output logic       do_trig_o
);

   import ic_pkg::*;

   localparam int CNT_W = $clog2(EVERY_B);
   localparam logic [CNT_W-1:0] LIM_A = CNT_W'(EVERY_A - 1);
   localparam logic [CNT_W-1:0] LIM_B = CNT_W'(EVERY_B - 1);

   mode_dec_t        dec;
   logic [3:0]       mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             sel_edge;
   logic             opp_edge;
   logic             presc_hit;
   logic             mode_chg;

   always_comb begin
      dec       = decode_mode(mode_i);
      mode_chg  = (mode_i != mode_q);
      sel_edge  = dec.use_fall ? fall_i : rise_i;
      opp_edge  = dec.use_fall ? rise_i : fall_i;
      unique case (dec.presc)
         PRE_A:   presc_hit = (cnt_q == LIM_A);
         PRE_B:   presc_hit = (cnt_q == LIM_B);
         default: presc_hit = 1'b1;
      endcase
      do_cap_o  = 1'b0;
      do_clr_o  = 1'b0;
      do_flag_o = 1'b0;
      do_trig_o = 1'b0;
      if (act_i) begin
         unique case (dec.grp)
            GRP_EDGE, GRP_PERIOD: begin
               do_cap_o  = sel_edge & presc_hit;
               do_flag_o = do_cap_o;
               do_clr_o  = do_cap_o & ren_i;
            end
            GRP_PULSE: begin
               do_clr_o  = sel_edge;
               do_cap_o  = opp_edge & armed_q;
               do_flag_o = do_cap_o;
            end
            GRP_STATE: begin
               do_cap_o  = rise_i | fall_i;
               do_flag_o = do_cap_o;
               do_clr_o  = do_cap_o & ren_i;
            end
            GRP_SPECIAL: begin
               do_cap_o  = sel_edge;
               do_trig_o = sel_edge;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 4'd0;
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         mode_q <= mode_i;
         if (mode_chg) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else if (act_i) begin
            if (dec.grp == GRP_EDGE && dec.presc != PRE_NONE && sel_edge)
               cnt_q <= presc_hit ? '0 : cnt_q + 1'b1;
            if (dec.grp == GRP_PULSE) begin
               if (sel_edge)      armed_q <= 1'b1;
               else if (do_cap_o) armed_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/ic_timebase.sv
module ic_timebase #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             clr_i,
   output logic [TMR_W-1:0] tmr_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tmr_o <= '0;
      else if (clr_i) tmr_o <= '0;
      else if (inc_i) tmr_o <= tmr_o + 1'b1;
   end

endmodule

// File: rtl/ic_capture_chan.sv
module ic_capture_chan #(
   parameter int TMR_W   = 16,
   parameter int EVERY_A = 4,
   parameter int EVERY_B = 16,
   parameter int IN_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       mode_i,
   input  logic             ren_i,
   input  logic             tmr_en_i,
   input  logic             cap_i,
   input  logic             flag_clr_i,
   output logic [TMR_W-1:0] tmr_o,
   output logic [TMR_W-1:0] cap_buf_o,
   output logic             cap_flag_o,
   output logic             trig_o,
   output logic [1:0]       phase_o
);

   generate
      if (TMR_W < 4 || TMR_W > 32) begin : g_bad_w
         $error("TMR_W must lie in 4..32");
      end
      if (EVERY_A < 2 || (EVERY_A & (EVERY_A - 1)) != 0) begin : g_bad_a
         $error("EVERY_A must be a power of two, at least 2");
      end
      if (EVERY_B <= EVERY_A || (EVERY_B & (EVERY_B - 1)) != 0) begin : g_bad_b
         $error("EVERY_B must be a power of two above EVERY_A");
      end
      if (IN_SYNC < 0 || IN_SYNC > 4) begin : g_bad_s
         $error("IN_SYNC must lie in 0..4");
      end
   endgenerate

   logic st_sample, st_act, st_wrap;
   logic pin_s;
   logic rise, fall;
   logic do_cap, do_clr, do_flag, do_trig;
   logic trig_q;

   ic_phase_gen u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_o     (phase_o),
      .st_sample_o (st_sample),
      .st_act_o    (st_act),
      .st_wrap_o   (st_wrap)
   );

   ic_in_sync #(.STAGES(IN_SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cap_i),
      .q_o   (pin_s)
   );

   ic_edge_sampler u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_i (st_sample),
      .pin_i    (pin_s),
      .rise_o   (rise),
      .fall_o   (fall)
   );

   ic_event_ctrl #(.EVERY_A(EVERY_A), .EVERY_B(EVERY_B)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode_i),
      .ren_i     (ren_i),
      .act_i     (st_act),
      .rise_i    (rise),
      .fall_i    (fall),
      .do_cap_o  (do_cap),
      .do_clr_o  (do_clr),
      .do_flag_o (do_flag),
      .do_trig_o (do_trig)
   );

   ic_timebase #(.TMR_W(TMR_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (tmr_en_i),
      .clr_i (do_clr | (trig_q & st_wrap)),
      .tmr_o (tmr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_buf_o  <= '0;
         cap_flag_o <= 1'b0;
         trig_q     <= 1'b0;
      end else begin
         trig_q <= do_trig;
         if (do_cap) cap_buf_o <= tmr_o;
         if (do_flag)         cap_flag_o <= 1'b1;
         else if (flag_clr_i) cap_flag_o <= 1'b0;
      end
   end

   assign trig_o = trig_q;

endmodule

// File: rtl/ic_capture_chan_chk.sv
module ic_capture_chan_chk #(
   parameter int TMR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       mode_i,
   input logic             tmr_en_i,
   input logic             flag_clr_i,
   input logic [TMR_W-1:0] tmr_o,
   input logic [TMR_W-1:0] cap_buf_o,
   input logic             cap_flag_o,
   input logic             trig_o,
   input logic [1:0]       phase_o
);

   localparam logic [TMR_W-1:0] ONE = {{(TMR_W-1){1'b0}}, 1'b1};

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o <= 2'd3) |=> (phase_o == $past(phase_o) + 2'd1)); // R2
   AST_FLAG_IN_PH4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_flag_o) |-> (phase_o == 2'd3)); // R2
   AST_BUF_IN_PH4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_buf_o) |-> (phase_o == 2'd3)); // R2
   AST_TRIG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> (mode_i[3:1] == 3'b111)); // R9
   AST_TRIG_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> !$rose(cap_flag_o)); // R9
   AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> (!trig_o && tmr_o == '0)); // R9
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 4'd0) |=> !$rose(cap_flag_o)); // R10
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && phase_o != 2'd2) |=> !cap_flag_o); // R11
   AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en_i && !trig_o && phase_o != 2'd2) |=> $stable(tmr_o)); // R12
   AST_TMR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en_i && !trig_o && phase_o != 2'd2) |=> (tmr_o == $past(tmr_o) + ONE)); // R12

endmodule

bind ic_capture_chan ic_capture_chan_chk #(.TMR_W(TMR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .tmr_en_i   (tmr_en_i),
   .flag_clr_i (flag_clr_i),
   .tmr_o      (tmr_o),
   .cap_buf_o  (cap_buf_o),
   .cap_flag_o (cap_flag_o),
   .trig_o     (trig_o),
   .phase_o    (phase_o)
);

// File: tb/test_ic_capture_chan.sv
module test_ic_capture_chan;

   localparam int TMR_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       mode_i = 4'd0;
   logic             ren_i = 1'b0;
   logic             tmr_en_i = 1'b1;
   logic             cap_i = 1'b0;
   logic             flag_clr_i = 1'b0;
   logic [TMR_W-1:0] tmr_o;
   logic [TMR_W-1:0] cap_buf_o;
   logic             cap_flag_o;
   logic             trig_o;
   logic [1:0]       phase_o;

   int nchk = 0;
   int nerr = 0;
   int trig_total = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ic_capture_chan #(.TMR_W(TMR_W), .EVERY_A(4), .EVERY_B(16), .IN_SYNC(0)) i_ic_capture_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_i),
      .ren_i      (ren_i),
      .tmr_en_i   (tmr_en_i),
      .cap_i      (cap_i),
      .flag_clr_i (flag_clr_i),
      .tmr_o      (tmr_o),
      .cap_buf_o  (cap_buf_o),
      .cap_flag_o (cap_flag_o),
      .trig_o     (trig_o),
      .phase_o    (phase_o)
   );

   always @(negedge clk) if (trig_o === 1'b1) trig_total++;

   typedef struct packed {
      logic [3:0]  mode;
      logic        ren;
      logic [3:0]  nhi;
      logic [3:0]  nlo;
      logic        chk;
      logic [15:0] cap;
      logic        flag;
      logic [1:0]  trigs;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{4'd1,  1'b1, 4'd3, 4'd2, 1'b1, 16'd19, 1'b1, 2'd0, 4'd3},  // R3 rising
      '{4'd2,  1'b1, 4'd2, 4'd5, 1'b1, 16'd27, 1'b1, 2'd0, 4'd3},  // R3 falling
      '{4'd5,  1'b1, 4'd4, 4'd4, 1'b1, 16'd31, 1'b1, 2'd0, 4'd5},  // R5 period
      '{4'd6,  1'b1, 4'd3, 4'd6, 1'b1, 16'd11, 1'b1, 2'd0, 4'd6},  // R6 high time
      '{4'd6,  1'b0, 4'd5, 4'd2, 1'b1, 16'd19, 1'b1, 2'd0, 4'd6},  // R6 ren ignored
      '{4'd7,  1'b1, 4'd3, 4'd4, 1'b1, 16'd15, 1'b1, 2'd0, 4'd6},  // R6 low time
      '{4'd7,  1'b0, 4'd2, 4'd3, 1'b1, 16'd11, 1'b1, 2'd0, 4'd6},  // R6 ren ignored
      '{4'd8,  1'b1, 4'd6, 4'd2, 1'b1, 16'd23, 1'b1, 2'd0, 4'd7},  // R7 any edge
      '{4'd14, 1'b1, 4'd2, 4'd3, 1'b1, 16'd18, 1'b0, 2'd2, 4'd9},  // R9 rising trigger
      '{4'd15, 1'b0, 4'd3, 4'd3, 1'b1, 16'd22, 1'b0, 2'd2, 4'd9},  // R9 falling trigger
      '{4'd0,  1'b1, 4'd3, 4'd3, 1'b0, 16'd0,  1'b0, 2'd0, 4'd10}, // R10 off
      '{4'd11, 1'b1, 4'd2, 4'd2, 1'b0, 16'd0,  1'b0, 2'd0, 4'd10}  // R10 unused code
   };

   task automatic chk_eq(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step_to(input logic [1:0] k);
      @(negedge clk);
      while (phase_o !== k) @(negedge clk);
   endtask

   task automatic clr_flag();
      step_to(2'd0);
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
   endtask

   task automatic rise_pulse();
      cap_i = 1'b1;
      step_to(2'd3);
      cap_i = 1'b0;
      step_to(2'd3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL R2: watchdog actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [TMR_W-1:0] c1, t0;
      logic [TMR_W-1:0] cb0;
      int tr0;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk_eq("R1 phase", phase_o, 0);
      chk_eq("R1 tmr", tmr_o, 0);
      rst_n = 1'b1;
      chk_eq("R1 buf", cap_buf_o, 0);
      chk_eq("R1 flag", cap_flag_o, 0);
      chk_eq("R1 trig", trig_o, 0);

      // R2 phase sequence
      for (int i = 1; i <= 4; i++) begin
         @(negedge clk);
         chk_eq("R2 phase step", phase_o, i % 4);
      end

      // R2 late edge then early edge
      mode_i = 4'd1;
      ren_i  = 1'b0;
      clr_flag();
      step_to(2'd1);
      cap_i = 1'b1;
      step_to(2'd3);
      chk_eq("R2 late edge not yet seen", cap_flag_o, 0);
      step_to(2'd3);
      chk_eq("R2 late edge next cycle", cap_flag_o, 1);
      cap_i = 1'b0;
      step_to(2'd3);
      clr_flag();
      chk_eq("R11 strobe clears", cap_flag_o, 0);
      step_to(2'd0);
      cap_i = 1'b1;
      step_to(2'd3);
      chk_eq("R2 early edge same cycle", cap_flag_o, 1);
      cap_i = 1'b0;
      step_to(2'd3);
      step_to(2'd3);
      chk_eq("R11 flag sticky", cap_flag_o, 1);

      // R11 set wins over clear
      clr_flag();
      step_to(2'd3);
      cap_i = 1'b1;
      step_to(2'd1);
      flag_clr_i = 1'b1;
      step_to(2'd3);
      chk_eq("R11 set beats clear", cap_flag_o, 1);
      flag_clr_i = 1'b0;
      cap_i = 1'b0;
      step_to(2'd3);

      // R8 reset-enable off then on, R3 capture
      ren_i = 1'b0;
      step_to(2'd3);
      cap_i = 1'b1;
      step_to(2'd3);
      c1 = cap_buf_o;
      chk_eq("R8 timer runs on", tmr_o, c1 + 1);
      cap_i = 1'b0;
      repeat (4) step_to(2'd3);
      cap_i = 1'b1;
      step_to(2'd3);
      chk_eq("R3 free-run difference", cap_buf_o, c1 + 20);
      cap_i = 1'b0;
      repeat (2) step_to(2'd3);
      ren_i = 1'b1;
      cap_i = 1'b1;
      step_to(2'd3);
      chk_eq("R8 timer cleared", tmr_o, 0);
      cap_i = 1'b0;
      step_to(2'd3);

      // R4 prescaled capture
      mode_i = 4'd3;
      step_to(2'd3);
      clr_flag();
      step_to(2'd3);
      repeat (3) rise_pulse();
      chk_eq("R4 three of four", cap_flag_o, 0);
      rise_pulse();
      chk_eq("R4 fourth edge", cap_flag_o, 1);
      mode_i = 4'd4;
      clr_flag();
      step_to(2'd3);
      repeat (15) rise_pulse();
      chk_eq("R4 fifteen of sixteen", cap_flag_o, 0);
      rise_pulse();
      chk_eq("R4 sixteenth edge", cap_flag_o, 1);
      mode_i = 4'd3;
      clr_flag();
      step_to(2'd3);
      repeat (2) rise_pulse();
      mode_i = 4'd1;
      step_to(2'd3);
      mode_i = 4'd3;
      step_to(2'd3);
      repeat (2) rise_pulse();
      chk_eq("R4 count restarts", cap_flag_o, 0);
      repeat (2) rise_pulse();
      chk_eq("R4 after restart", cap_flag_o, 1);

      // R12 mode changes leave the timer alone
      tmr_en_i = 1'b0;
      step_to(2'd3);
      t0 = tmr_o;
      mode_i = 4'd5;  @(negedge clk);
      mode_i = 4'd8;  @(negedge clk);
      mode_i = 4'd14; @(negedge clk);
      mode_i = 4'd0;  @(negedge clk);
      chk_eq("R12 hold across modes", tmr_o, t0);
      tmr_en_i = 1'b1;
      @(negedge clk);
      t0 = tmr_o;
      mode_i = 4'd7;
      @(negedge clk);
      chk_eq("R12 count across mode change", tmr_o, t0 + 1);

      // R9 special trigger
      mode_i = 4'd14;
      clr_flag();
      step_to(2'd3);
      tr0 = trig_total;
      cap_i = 1'b1;
      step_to(2'd3);
      chk_eq("R9 trigger high", trig_o, 1);
      chk_eq("R9 no flag", cap_flag_o, 0);
      @(negedge clk);
      chk_eq("R9 timer cleared in phase 1", tmr_o, 0);
      chk_eq("R9 trigger one clock", trig_total - tr0, 1);
      cap_i = 1'b0;
      step_to(2'd3);

      // vector table
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec %0d", VEC[i].req, i);
         mode_i = 4'd0;
         clr_flag();
         step_to(2'd3);
         mode_i = VEC[i].mode;
         ren_i  = VEC[i].ren;
         cb0 = cap_buf_o;
         tr0 = trig_total;
         cap_i = 1'b1;
         repeat (VEC[i].nhi) step_to(2'd3);
         cap_i = 1'b0;
         repeat (VEC[i].nlo) step_to(2'd3);
         cap_i = 1'b1;
         repeat (VEC[i].nhi) step_to(2'd3);
         cap_i = 1'b0;
         repeat (3) step_to(2'd3);
         if (VEC[i].chk) chk_eq({tag, " capture"}, cap_buf_o, VEC[i].cap);
         else            chk_eq({tag, " buffer unchanged"}, cap_buf_o, cb0);
         chk_eq({tag, " flag"}, cap_flag_o, VEC[i].flag);
         chk_eq({tag, " trigger pulses"}, trig_total - tr0, VEC[i].trigs);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule